// File: doc/BRIEF.md
# RTC Time ASCII Serial Streamer

This block turns a packed clock-time word (seconds, minutes and hours, each held as one BCD byte) into a short line of printable text. It sends that text as asynchronous serial characters on a single transmit line. A one-cycle start strobe captures the time word into a holding register. The block then emits a fixed nine-character message. Each field appears on its own terminal line, preceded by a line-feed, and the fields go out seconds first, then minutes, then hours.

Inside are a bit-rate tick generator, a byte-serial transmitter that frames each character as one start bit, eight data bits and one stop bit, and a sequencer that picks the character for each message slot. A busy output tells the caller when a new strobe will be taken. Strobes that arrive while busy is high are dropped.

The bit period is set by two parameters: the system clock rate and the serial rate. With the default 50 MHz clock and 9600 baud, each bit lasts 5208 clocks.

Top module: `rtc_ascii_uart`

## Requirements
- R1: While and right after reset, the serial line is high and busy is low.
- R2: Every character is framed as a low start bit, eight data bits with the least significant bit first, and a high stop bit. Each bit lasts DIV clocks, where DIV = round(CLK_HZ/BAUD) (5208 by default). A full message keeps busy high for at least 90*DIV cycles and at most 90*DIV plus a few cycles of inter-character gap.
- R3: One message is exactly nine characters, in this order: 0x0A, seconds upper digit, seconds lower digit, 0x0A, minutes upper digit, minutes lower digit, 0x0A, hours upper digit, hours lower digit. Seconds are bits [7:0] of the time word, minutes bits [15:8] and hours bits [23:16].
- R4: Each digit character is 0x30 plus a 4-bit nibble of the field. The upper nibble is sent before the lower one, and a nibble above 9 still maps to 0x30 plus its value.
- R5: Before conversion, bit 7 of seconds, bit 7 of minutes and bits 7:6 of hours are forced to zero.
- R6: The time word is captured when a strobe is accepted. Later changes on the time input do not alter the message in progress.
- R7: A strobe that arrives while busy is high is ignored. No extra message follows, and the line stays high after busy falls.
- R8: busy rises on the clock edge that samples an accepted strobe. It stays high until the end of the last stop bit, and no character is ever started while busy is low.
- R9: Whenever busy is low, the serial line is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| time_in | input | 24 | Packed BCD time: hours [23:16], minutes [15:8], seconds [7:0] |
| start | input | 1 | Request to send one time message |
| tx_line | output | 1 | Serial transmit line, idle high |
| busy | output | 1 | High while a message is being sent |

## Verification
The end of a message and the acceptance of a new strobe can meet in the same cycle. The stop-bit tick of the final character is the cycle in which busy clears, and a strobe held high across that point must neither be lost nor taken twice. The bench holds start high through a complete message, so the strobe is present in the completion cycle and in the cycle after it. It then counts how long busy stays low: exactly one cycle is accepted. The second message must carry the time word present when the strobe was re-accepted, not the earlier one.

// File: rtl/rtc_ascii_pkg.sv
package rtc_ascii_pkg;

    localparam int          DATA_W      = 8;
    localparam int          FIELD_CNT   = 3;
    localparam int          SLOT_PER_F  = 3;
    localparam int          MSG_LEN     = FIELD_CNT * SLOT_PER_F;
    localparam int          IDX_W       = $clog2(MSG_LEN);
    localparam logic [7:0]  LINE_FEED   = 8'h0A;
    localparam logic [7:0]  DIGIT_BASE  = 8'h30;

    typedef struct packed {
        logic [7:0] hr;
        logic [7:0] mn;
        logic [7:0] sc;
    } clk_word_t;

    typedef enum logic [1:0] {
        TX_IDLE,
        TX_START,
        TX_DATA,
        TX_STOP
    } tx_state_t;

    typedef enum logic [1:0] {
        SQ_IDLE,
        SQ_ISSUE,
        SQ_WAIT
    } sq_state_t;

    // Clear bits that hold no time value
    function automatic clk_word_t strip_word(input clk_word_t w);
        clk_word_t r;
        r.sc = {1'b0, w.sc[6:0]};
        r.mn = {1'b0, w.mn[6:0]};
        r.hr = {2'b00, w.hr[5:0]};
        return r;
    endfunction

    function automatic logic [7:0] nib_to_char(input logic [3:0] n);
        return DIGIT_BASE + {4'h0, n};
    endfunction

    // Character for one message slot
    function automatic logic [7:0] slot_char(input clk_word_t w,
                                             input logic [IDX_W-1:0] idx);
        logic [7:0] fld;
        int         f;
        int         p;
        f = int'(idx) / SLOT_PER_F;
        p = int'(idx) % SLOT_PER_F;
        case (f)
            0:       fld = w.sc;
            1:       fld = w.mn;
            default: fld = w.hr;
        endcase
        case (p)
            0:       return LINE_FEED;
            1:       return nib_to_char(fld[7:4]);
            default: return nib_to_char(fld[3:0]);
        endcase
    endfunction

endpackage

// File: rtl/rtc_baud_gen.sv
module rtc_baud_gen #(
    parameter int DIV = 5208
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic tick
);
    localparam int CW = $clog2(DIV + 1);
    localparam logic [CW-1:0] LAST = CW'(DIV - 1);

    logic [CW-1:0] cnt_q;

    assign tick = run && (cnt_q == LAST);

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt_q <= '0;
        end else if (cnt_q == LAST) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/rtc_uart_tx.sv
module rtc_uart_tx
    import rtc_ascii_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [DATA_W-1:0] data,
    input  logic              tick,
    output logic              run,
    output logic              done,
    output logic              line
);
    localparam int BW = $clog2(DATA_W);

    tx_state_t         st_q;
    logic [DATA_W-1:0] sh_q;
    logic [BW-1:0]     bit_q;
    logic              line_q;

    assign run  = (st_q != TX_IDLE);
    assign done = (st_q == TX_STOP) && tick;
    assign line = line_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= TX_IDLE;
            sh_q   <= '0;
            bit_q  <= '0;
            line_q <= 1'b1;
        end else begin
            case (st_q)
                TX_IDLE: begin
                    line_q <= 1'b1;
                    if (load) begin
                        sh_q   <= data;
                        line_q <= 1'b0;
                        st_q   <= TX_START;
                    end
                end
                TX_START: begin
                    if (tick) begin
                        line_q <= sh_q[0];
                        sh_q   <= sh_q >> 1;
                        bit_q  <= '0;
                        st_q   <= TX_DATA;
                    end
                end
                TX_DATA: begin
                    if (tick) begin
                        if (bit_q == BW'(DATA_W - 1)) begin
                            line_q <= 1'b1;
                            st_q   <= TX_STOP;
                        end else begin
                            line_q <= sh_q[0];
                            sh_q   <= sh_q >> 1;
                            bit_q  <= bit_q + 1'b1;
                        end
                    end
                end
                default: begin
                    line_q <= 1'b1;
                    if (tick) begin
                        st_q <= TX_IDLE;
                    end
                end
            endcase
        end
    end
endmodule

// File: rtl/rtc_msg_seq.sv
module rtc_msg_seq
    import rtc_ascii_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [23:0]       time_in,
    input  logic              tx_done,
    output logic              tx_load,
    output logic [DATA_W-1:0] tx_data,
    output logic              busy
);
    sq_state_t        st_q;
    clk_word_t        hold_q;
    logic [IDX_W-1:0] idx_q;

    assign busy    = (st_q != SQ_IDLE);
    assign tx_load = (st_q == SQ_ISSUE);
    assign tx_data = slot_char(hold_q, idx_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= SQ_IDLE;
            hold_q <= '0;
            idx_q  <= '0;
        end else begin
            case (st_q)
                SQ_IDLE: begin
                    if (start) begin
                        hold_q <= strip_word(clk_word_t'(time_in));
                        idx_q  <= '0;
                        st_q   <= SQ_ISSUE;
                    end
                end
                SQ_ISSUE: begin
                    st_q <= SQ_WAIT;
                end
                default: begin
                    if (tx_done) begin
                        if (idx_q == IDX_W'(MSG_LEN - 1)) begin
                            st_q <= SQ_IDLE;
                        end else begin
                            idx_q <= idx_q + 1'b1;
                            st_q  <= SQ_ISSUE;
                        end
                    end
                end
            endcase
        end
    end
endmodule

// File: rtl/rtc_ascii_uart.sv
module rtc_ascii_uart
    import rtc_ascii_pkg::*;
#(
    parameter int CLK_HZ = 50_000_000,
    parameter int BAUD   = 9600
) (
    input  logic        clk,
    input  logic        rst,
    input  logic [23:0] time_in,
    input  logic        start,
    output logic        tx_line,
    output logic        busy
);
    localparam int DIV = (CLK_HZ + BAUD / 2) / BAUD;

    logic              baud_tick;
    logic              tx_run;
    logic              tx_done;
    logic              tx_load;
    logic [DATA_W-1:0] tx_data;

    rtc_msg_seq u_seq (
        .clk     (clk),
        .rst     (rst),
        .start   (start),
        .time_in (time_in),
        .tx_done (tx_done),
        .tx_load (tx_load),
        .tx_data (tx_data),
        .busy    (busy)
    );

    rtc_baud_gen #(.DIV(DIV)) u_baud (
        .clk  (clk),
        .rst  (rst),
        .run  (tx_run),
        .tick (baud_tick)
    );

    rtc_uart_tx u_tx (
        .clk  (clk),
        .rst  (rst),
        .load (tx_load),
        .data (tx_data),
        .tick (baud_tick),
        .run  (tx_run),
        .done (tx_done),
        .line (tx_line)
    );
endmodule

// File: rtl/rtc_ascii_uart_chk.sv
module rtc_ascii_uart_chk (
    input logic clk,
    input logic rst,
    input logic start,
    input logic busy,
    input logic tx_line,
    input logic tick,
    input logic load
);
    // R9
    idle_line_high_chk: assert property (@(posedge clk) disable iff (rst)
        !busy |-> tx_line);

    // R8
    busy_rise_chk: assert property (@(posedge clk) disable iff (rst)
        (start && !busy) |=> busy);

    // R8
    load_in_busy_chk: assert property (@(posedge clk) disable iff (rst)
        load |-> busy);

    // R2
    start_bit_busy_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(tx_line) |-> busy);

    // R2
    line_step_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(tx_line) |-> $past(tick || load));

    // R8
    busy_end_tick_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> $past(tick));
endmodule

bind rtc_ascii_uart rtc_ascii_uart_chk u_chk (
    .clk     (clk),
    .rst     (rst),
    .start   (start),
    .busy    (busy),
    .tx_line (tx_line),
    .tick    (baud_tick),
    .load    (tx_load)
);

// File: tb/rtc_ascii_uart_bench.sv
`timescale 1ns/1ps
module rtc_ascii_uart_bench;
    localparam int CLK_HZ = 800;
    localparam int BAUD   = 100;
    localparam int DIV    = 8;
    localparam int MSG_BITS = 90;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [23:0] time_in = '0;
    logic        start = 1'b0;
    logic        tx_line;
    logic        busy;

    int total = 0;
    int bad   = 0;
    int run_len  = 0;
    int last_len = 0;
    logic busy_d = 1'b0;

    always #10 clk = ~clk;

    rtc_ascii_uart #(.CLK_HZ(CLK_HZ), .BAUD(BAUD)) u_rtc_ascii_uart (
        .clk     (clk),
        .rst     (rst),
        .time_in (time_in),
        .start   (start),
        .tx_line (tx_line),
        .busy    (busy)
    );

    always @(negedge clk) begin
        if (busy) run_len = run_len + 1;
        else if (busy_d) begin
            last_len = run_len;
            run_len  = 0;
        end
        busy_d = busy;
    end

    function automatic logic [7:0] exp_char(input logic [23:0] w, input int i);
        logic [7:0] f;
        logic [7:0] m;
        case (i / 3)
            0: begin f = w[7:0];   m = 8'h7F; end
            1: begin f = w[15:8];  m = 8'h7F; end
            default: begin f = w[23:16]; m = 8'h3F; end
        endcase
        f = f & m;
        case (i % 3)
            0:       return 8'h0A;
            1:       return 8'h30 + {4'h0, f[7:4]};
            default: return 8'h30 + {4'h0, f[3:0]};
        endcase
    endfunction

    task automatic check(input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic rx_char(output logic [7:0] c, output logic ok);
        int lim = 0;
        ok = 1'b1;
        c  = '0;
        @(negedge clk);
        while (tx_line !== 1'b0 && lim < 40 * DIV) begin
            @(negedge clk);
            lim++;
        end
        repeat (DIV / 2) @(negedge clk);
        if (tx_line !== 1'b0) ok = 1'b0;
        for (int b = 0; b < 8; b++) begin
            repeat (DIV) @(negedge clk);
            c[b] = tx_line;
        end
        repeat (DIV) @(negedge clk);
        if (tx_line !== 1'b1) ok = 1'b0;
    endtask

    task automatic pulse_start(input logic [23:0] w);
        @(negedge clk);
        time_in = w;
        start   = 1'b1;
        @(negedge clk);
        start   = 1'b0;
        // R8: busy high in the cycle after the accepting edge
        check("R8 busy after strobe", {31'd0, busy}, 32'd1);
    endtask

    // Decode one message; optional mid-message disturbances
    task automatic rx_msg(input logic [23:0] w, input logic disturb);
        logic [7:0] c;
        logic       ok;
        for (int i = 0; i < 9; i++) begin
            rx_char(c, ok);
            check("R2 frame", {31'd0, ok}, 32'd1);
            check(i % 3 == 0 ? "R3 line feed" : "R4 R5 digit",
                  {24'd0, c}, {24'd0, exp_char(w, i)});
            if (disturb && i == 2) begin
                time_in = ~w;           // R6
                start   = 1'b1;         // R7
                @(negedge clk);
                start   = 1'b0;
            end
        end
    endtask

    task automatic finish_msg();
        int lim = 0;
        while (busy && lim < 4 * DIV) begin
            @(negedge clk);
            lim++;
        end
        @(negedge clk);
        check("R8 busy falls", {31'd0, busy}, 32'd0);
        check("R2 message length lo", {31'd0, last_len >= MSG_BITS * DIV}, 32'd1);
        check("R2 message length hi", {31'd0, last_len <= MSG_BITS * DIV + 20}, 32'd1);
    endtask

    task automatic quiet_after(input string req);
        logic hi = 1'b1;
        for (int k = 0; k < 3 * DIV; k++) begin
            @(negedge clk);
            if (tx_line !== 1'b1 || busy !== 1'b0) hi = 1'b0;
        end
        check(req, {31'd0, hi}, 32'd1);
    endtask

    task automatic main_seq();
        logic [23:0] w;
        logic [23:0] w2;
        int          gap;
        int          seed;
        repeat (3) @(negedge clk);
        // R1
        check("R1 line after reset", {31'd0, tx_line}, 32'd1);
        check("R1 busy after reset", {31'd0, busy}, 32'd0);
        rst = 1'b0;
        repeat (2) @(negedge clk);
        check("R9 idle line", {31'd0, tx_line}, 32'd1);

        // Directed fields: normal, zero, all-ones (mask, nibble above 9)
        w = 24'h235959; pulse_start(w); rx_msg(w, 1'b0); finish_msg();
        w = 24'h000000; pulse_start(w); rx_msg(w, 1'b0); finish_msg();
        w = 24'hFFFFFF; pulse_start(w); rx_msg(w, 1'b0); finish_msg();
        quiet_after("R9 idle after message");

        // R6 and R7: input change and extra strobe mid-message
        w = 24'h124507; pulse_start(w); rx_msg(w, 1'b1); finish_msg();
        quiet_after("R7 no extra message");

        // Completion and strobe in the same cycle
        w  = 24'h081530;
        w2 = 24'h194422;
        @(negedge clk);
        time_in = w;
        start   = 1'b1;
        rx_msg(w, 1'b0);
        time_in = w2;
        while (busy) @(negedge clk);
        gap = 0;
        while (!busy && gap < 10) begin
            @(negedge clk);
            gap++;
        end
        check("R8 busy low gap", gap, 32'd1);
        start = 1'b0;
        rx_msg(w2, 1'b0);
        finish_msg();

        // Random words
        seed = $urandom(32'd1234);
        for (int n = 0; n < 8; n++) begin
            w = $urandom() & 24'hFFFFFF;
            pulse_start(w);
            rx_msg(w, 1'b0);
            finish_msg();
        end
        quiet_after("R9 idle at end");
    endtask

    initial begin
        fork
            main_seq();
            begin
                repeat (150000) @(posedge clk);
                total++;
                bad++;
                $display("FAIL watchdog actual=timeout expected=completion");
            end
        join_any
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule